// File: doc/BRIEF.md
# Four-Channel I/Q Sample Output Port

This block gathers I/Q samples from four receive channels and hands them, one word at a time, to a single 16-bit output port. Each channel owns a one-sample holding register. A new sample for a channel always lands in that channel's register, and replaces any sample there that has not yet been read. A fixed-priority picker chooses the next channel with an unread sample. The output stage then drives the data word, an I/Q phase flag and the 2-bit index of the source channel.

The output side is a valid/ready stream. `out_req` is valid and `out_ack` is ready. A word moves on a rising clock edge where both are high. While `out_req` is high and `out_ack` is low, the reader applies back-pressure, and the word on the port holds still. The input side never stalls. A pulse on `in_valid[c]` is always accepted into the holding register of channel c, so a slow reader loses old samples and never holds up the sample chain.

`cfg_concurrent` picks the format. When it is low (interleaved), each sample takes two words: the full 16-bit I word, then the full 16-bit Q word. When it is high (concurrent), each sample is one word: the upper byte of I followed by the upper byte of Q. The format is captured when a sample is taken for output.

Top module: `iq_port_mux`

## Requirements
- R1: After reset, `out_req` is low and no channel holds an unread sample.
- R2: A sample written on an edge makes `out_req` high after the next edge. It stays high while any channel holds an unread sample or a word is still to be sent.
- R3: When several channels hold unread samples, they are sent lowest index first: channel 0, then 1, 2 and 3.
- R4: `out_tag` carries the binary index (0 to 3) of the channel whose data is on `out_data`.
- R5: In interleaved mode (`cfg_concurrent`=0), a sample is sent as two words. The first word is I[15:0] with `out_iq`=1. The next word is Q[15:0] with `out_iq`=0 and the same tag.
- R6: In concurrent mode (`cfg_concurrent`=1), a sample is one word {I[15:8], Q[15:8]}: I's upper byte sits in `out_data`[15:8] and Q's upper byte in `out_data`[7:0]. `out_iq` is 1 on every such word, so it stays high across back-to-back channels.
- R7: A new sample for a channel replaces that channel's unread sample. It never changes the sample held by any other channel.
- R8: A sample that arrives for a channel whose data is on the port does not change the words in flight. It is sent at that channel's next service.
- R9: While `out_req`=1 and `out_ack`=0, `out_data`, `out_iq` and `out_tag` hold their values. A word transfers only on an edge where both are high.
- R10: The format is captured when a sample is taken for output. A change of `cfg_concurrent` between the I and Q words does not split the pair, and it applies to the next sample taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_concurrent | input | 1 | 0: interleaved 16-bit I then Q; 1: packed 8-bit I and 8-bit Q |
| in_valid | input | 4 | Per-channel sample strobe |
| in_i | input | 64 | I samples, channel c in bits [16c+15:16c] |
| in_q | input | 64 | Q samples, channel c in bits [16c+15:16c] |
| out_req | output | 1 | Output word valid |
| out_ack | input | 1 | Reader ready |
| out_data | output | 16 | Output word |
| out_iq | output | 1 | High on an I word or a packed word |
| out_tag | output | 2 | Source channel index |

## Verification
The bench stalls the reader while several channels fill at once, then checks that the tags come out 0, 1, 2, 3. A picker with a wrong or rotating priority would give a different order. It writes the same channel twice during a stall and expects only the second sample, with a neighbour's data untouched. A bank that queued samples, or that wrote through the wrong index, would show the stale or foreign word. It rewrites a channel and flips the format while that channel's I word is waiting on the port. A design that reads the Q word live from the holding register, or that samples the format per word, would send a mixed pair. Random traffic with random back-pressure is compared on every cycle against a bench model, which catches words that move during a stall or get lost on an edge.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  // Output word formats
  typedef enum logic {
    FMT_SPLIT  = 1'b0,
    FMT_PACKED = 1'b1
  } fmt_e;
endpackage

// File: rtl/iqp_hold_bank.sv
module iqp_hold_bank #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_en,
  input  logic [NCH*DW-1:0] wr_i,
  input  logic [NCH*DW-1:0] wr_q,
  input  logic [NCH-1:0]    take,
  output logic [NCH-1:0]    pend,
  output logic [NCH*DW-1:0] hold_i,
  output logic [NCH*DW-1:0] hold_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[c]             <= 1'b0;
        hold_i[c*DW +: DW]  <= '0;
        hold_q[c*DW +: DW]  <= '0;
      end else if (wr_en[c]) begin
        // a fresh sample always wins, even on the edge it is taken
        pend[c]             <= 1'b1;
        hold_i[c*DW +: DW]  <= wr_i[c*DW +: DW];
        hold_q[c*DW +: DW]  <= wr_q[c*DW +: DW];
      end else if (take[c]) begin
        pend[c]             <= 1'b0;
      end
    end

    // R7
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[c] |=> $stable(hold_i[c*DW +: DW]) && $stable(hold_q[c*DW +: DW]));
  end
endmodule

// File: rtl/iqp_prio_pick.sv
module iqp_prio_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = |req;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        gnt    = '0;
        gnt[k] = 1'b1;
        idx    = IW'(k);
      end
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (any == (gnt != '0)));
  // R3
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> (((gnt - 1'b1) & req) == '0));
endmodule

// File: rtl/iqp_port_shifter.sv
module iqp_port_shifter
  import iq_port_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_concurrent,
  input  logic          pick_any,
  input  logic [CW-1:0] pick_idx,
  input  logic [DW-1:0] sel_i,
  input  logic [DW-1:0] sel_q,
  output logic          take,
  output logic          out_req,
  input  logic          out_ack,
  output logic [DW-1:0] out_data,
  output logic          out_iq,
  output logic [CW-1:0] out_tag
);
  localparam int HW = DW / 2;

  logic          q_due;
  logic [DW-1:0] q_save;
  logic          fire;
  fmt_e          fmt;

  assign fmt  = cfg_concurrent ? FMT_PACKED : FMT_SPLIT;
  assign fire = !out_req || out_ack;
  assign take = fire && !q_due && pick_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_req  <= 1'b0;
      out_data <= '0;
      out_iq   <= 1'b0;
      out_tag  <= '0;
      q_due    <= 1'b0;
      q_save   <= '0;
    end else if (fire) begin
      if (q_due) begin
        out_req  <= 1'b1;
        out_data <= q_save;
        out_iq   <= 1'b0;
        q_due    <= 1'b0;
      end else if (pick_any) begin
        out_req <= 1'b1;
        out_tag <= pick_idx;
        out_iq  <= 1'b1;
        if (fmt == FMT_PACKED) begin
          out_data <= {sel_i[DW-1 -: HW], sel_q[DW-1 -: HW]};
        end else begin
          out_data <= sel_i;
          q_save   <= sel_q;
          q_due    <= 1'b1;
        end
      end else begin
        out_req <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req && $stable(out_data) && $stable(out_iq) && $stable(out_tag));
  // R5
  q_after_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack && q_due) |=> out_req && !out_iq && $stable(out_tag));
endmodule

// File: rtl/iq_port_mux.sv
module iq_port_mux #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_concurrent,
  input  logic [NCH-1:0]    in_valid,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DW-1:0]     out_data,
  output logic              out_iq,
  output logic [CW-1:0]     out_tag
);
  logic [NCH-1:0]    pend;
  logic [NCH-1:0]    gnt;
  logic [NCH-1:0]    take_vec;
  logic [NCH*DW-1:0] hold_i;
  logic [NCH*DW-1:0] hold_q;
  logic [CW-1:0]     pick_idx;
  logic              pick_any;
  logic              take;
  logic [DW-1:0]     sel_i;
  logic [DW-1:0]     sel_q;

  iqp_hold_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid), .wr_i(in_i), .wr_q(in_q),
    .take(take_vec), .pend(pend), .hold_i(hold_i), .hold_q(hold_q)
  );

  iqp_prio_pick #(.N(NCH)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .req(pend), .gnt(gnt), .idx(pick_idx), .any(pick_any)
  );

  assign take_vec = gnt & {NCH{take}};
  assign sel_i    = hold_i[pick_idx*DW +: DW];
  assign sel_q    = hold_q[pick_idx*DW +: DW];

  iqp_port_shifter #(.DW(DW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cfg_concurrent(cfg_concurrent),
    .pick_any(pick_any), .pick_idx(pick_idx), .sel_i(sel_i), .sel_q(sel_q),
    .take(take), .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data), .out_iq(out_iq), .out_tag(out_tag)
  );

  // R2
  req_on_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> out_req);
endmodule

// File: tb/sim_iq_port_mux.sv
module sim_iq_port_mux;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_concurrent = 1'b0;
  logic [NCH-1:0]  in_valid = '0;
  logic [NCH*DW-1:0] in_i = '0;
  logic [NCH*DW-1:0] in_q = '0;
  logic            out_req;
  logic            out_ack = 1'b0;
  logic [DW-1:0]   out_data;
  logic            out_iq;
  logic [1:0]      out_tag;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  iq_port_mux #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_concurrent(cfg_concurrent),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data), .out_iq(out_iq), .out_tag(out_tag)
  );

  // bench model built from the requirements
  logic [NCH-1:0] m_pend;
  logic [15:0]    m_hi [NCH];
  logic [15:0]    m_hq [NCH];
  logic           m_req, m_iq, m_due, m_packed, m_found;
  logic [15:0]    m_data, m_qs;
  logic [1:0]     m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_req = 0; m_iq = 0; m_due = 0; m_data = '0; m_tag = '0;
      m_packed = 0;
    end else begin
      if (!m_req || out_ack) begin
        if (m_due) begin
          m_data = m_qs; m_iq = 0; m_due = 0; m_req = 1;
        end else begin
          m_found = 0;
          for (int c = 0; c < NCH; c++) begin
            if (!m_found && m_pend[c]) begin
              m_found = 1; m_pend[c] = 0; m_req = 1; m_iq = 1; m_tag = 2'(c);
              m_packed = cfg_concurrent;
              if (cfg_concurrent) m_data = {m_hi[c][15:8], m_hq[c][15:8]};
              else begin m_data = m_hi[c]; m_qs = m_hq[c]; m_due = 1; end
            end
          end
          if (!m_found) m_req = 0;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (in_valid[c]) begin
          m_hi[c] = in_i[c*DW +: DW]; m_hq[c] = in_q[c*DW +: DW]; m_pend[c] = 1;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic cmp();
    chk(out_req == m_req, "R2", 32'(out_req), 32'(m_req));
    if (m_req) begin
      chk(out_tag == m_tag, "R4", 32'(out_tag), 32'(m_tag));
      chk(out_iq == m_iq, m_packed ? "R6" : "R5", 32'(out_iq), 32'(m_iq));
      chk(out_data == m_data, m_packed ? "R6" : "R5", 32'(out_data), 32'(m_data));
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmp();
    in_valid = '0;
  endtask

  task automatic wr(input int c, input logic [15:0] vi, input logic [15:0] vq);
    in_valid[c] = 1'b1;
    in_i[c*DW +: DW] = vi;
    in_q[c*DW +: DW] = vq;
  endtask

  task automatic flush();
    out_ack = 1'b1;
    repeat (10) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_req == 1'b0, "R1", 32'(out_req), 32'h0);
    rst_n = 1'b1;
    step();
    chk(out_req == 1'b0, "R1", 32'(out_req), 32'h0);

    // R3 / R6: all four channels at once, packed, reader stalled
    out_ack = 1'b0; cfg_concurrent = 1'b1;
    step();
    for (int c = 0; c < NCH; c++) wr(c, 16'(16'h1100 * (c + 1)), 16'(16'h0A00 + c * 16'h0100));
    step(); step(); step();
    chk(out_tag == 2'd0, "R3", 32'(out_tag), 32'h0);
    out_ack = 1'b1;
    for (int k = 1; k < NCH; k++) begin
      step();
      chk(out_tag == 2'(k), "R3", 32'(out_tag), 32'(k));
      chk(out_iq == 1'b1, "R6", 32'(out_iq), 32'h1);
      chk(out_data == {8'(8'h11 * (k + 1)), 8'(8'h0A + k)}, "R6", 32'(out_data),
          32'({8'(8'h11 * (k + 1)), 8'(8'h0A + k)}));
    end
    flush();

    // R7 / R9: overwrite while stalled
    out_ack = 1'b0;
    step(); wr(0, 16'hAB00, 16'hCD00);
    step(); wr(2, 16'h1200, 16'h3400);
    step(); wr(2, 16'h5600, 16'h7800); wr(3, 16'h9A00, 16'hBC00);
    step(); step();
    held = out_data;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(out_data == held && out_tag == 2'd0, "R9", 32'(out_data), 32'(held));
    end
    out_ack = 1'b1;
    step();
    chk(out_tag == 2'd2 && out_data == 16'h5678, "R7", 32'({out_tag, out_data}), 32'h2_5678);
    step();
    chk(out_tag == 2'd3 && out_data == 16'h9ABC, "R7", 32'({out_tag, out_data}), 32'h3_9ABC);
    flush();

    // R8 / R10: new sample and format change while I word is on the port
    out_ack = 1'b0; cfg_concurrent = 1'b0;
    step(); wr(1, 16'h1357, 16'h2468);
    step(); step();
    step(); wr(1, 16'hFEDC, 16'hBA98); cfg_concurrent = 1'b1;
    step(); step();
    chk(out_data == 16'h1357 && out_iq && out_tag == 2'd1, "R8", 32'(out_data), 32'h1357);
    out_ack = 1'b1;
    step();
    chk(out_data == 16'h2468 && !out_iq, "R10", 32'({out_iq, out_data}), 32'h0_2468);
    step();
    chk(out_data == 16'hFEBA && out_iq && out_tag == 2'd1, "R8", 32'(out_data), 32'hFEBA);
    flush();

    // random traffic with random back-pressure, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      step();
      out_ack = ($urandom % 10) < 7;
      if (($urandom % 64) == 0) cfg_concurrent = ~cfg_concurrent;
      for (int c = 0; c < NCH; c++)
        if (($urandom % 4) == 0) wr(c, 16'($urandom), 16'($urandom));
    end
    flush();
    chk(out_req == 1'b0, "R2", 32'(out_req), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule